// File: doc/BRIEF.md
# Timer Compare/Capture Channel

This block is one general register slot that sits beside a free-running timer counter. A 4-bit control field sets what the slot does. In compare mode the slot drives a pin. Writing the control field sets the starting level of the pin. After that, each time the counter reaches the register value, the slot drives the pin low, drives it high or inverts it. In capture mode the slot copies the counter value into its register. It does this on selected edges of an input pin, or on count events that come from the counter of a neighbouring channel.

The counter value, the pin input and the neighbour's count events all arrive from outside the block. Software loads the control field and the register through a simple write port. The register value is always visible on an output. A single flag output pulses for one cycle on each compare match and on each capture. Counter generation and clock prescaling belong to other blocks.

Top module: `tmr_cc_chan`

## Requirements
- R1: After reset the control field is 0000, the register reads all ones, `pin_o` is 0, and `pin_oe_o` and `flag_o` are 0.
- R2: Control bit 3 = 0 selects compare mode. Codes 0000 and 0100 hold `pin_oe_o` low. Every compare code whose bits [1:0] are not 00 drives `pin_oe_o` high.
- R3: A write of compare code 0001, 0010 or 0011 sets `pin_o` to 0 at the same clock edge that stores the field. A write of 0101, 0110 or 0111 sets `pin_o` to 1 at that edge.
- R4: A compare match starts in the first cycle in which `cnt_i` equals the register. At the next edge the pin changes according to bits [1:0] of the code: 01 drives 0, 10 drives 1, 11 inverts. A run of equal cycles acts only once.
- R5: In compare mode, `flag_o` is high for exactly one cycle, in the cycle after a match starts.
- R6: Control bit 3 = 1 selects capture mode, and `pin_oe_o` is then low.
- R7: In capture mode `pin_i` passes through two synchroniser flops before edge detection. Bits [1:0] = 00 capture on a rising edge, 01 on a falling edge, and 1x on both edges. If `pin_i` changes before edge k, the register holds the value that `cnt_i` had before edge k+2, and `flag_o` is high in the same cycle the new value appears.
- R8: Capture codes 11xx ignore `pin_i`. In these codes, when `nb_cnt_evt_i` is high at a clock edge, the register loads `cnt_i` at that edge and `flag_o` is high for the following cycle.
- R9: While `nb_fast_clk_i` is high, neighbour events cause no capture, and neither the register nor `flag_o` changes.
- R10: A bus write to the register (`wr_reg_i`) overrides a capture in the same cycle, and the register takes `wdata_i`.
- R11: Under the disabled compare codes 0000 and 0100 a match still pulses `flag_o`, but `pin_o` keeps its level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_ctl_i | input | 1 | Writes `wdata_i[3:0]` into the control field |
| wr_reg_i | input | 1 | Writes `wdata_i` into the general register |
| wdata_i | input | CNT_W | Bus write data |
| cnt_i | input | CNT_W | Current value of the timer counter |
| pin_i | input | 1 | Capture input pin (asynchronous) |
| nb_cnt_evt_i | input | 1 | Count-up or count-down event of the neighbour counter |
| nb_fast_clk_i | input | 1 | Neighbour counter runs on the undivided clock |
| pin_o | output | 1 | Compare output level |
| pin_oe_o | output | 1 | Compare output enable |
| flag_o | output | 1 | One-cycle pulse on a compare match or a capture |
| gr_o | output | CNT_W | Current register value |

## Verification
The hardest case to reach from the ports is a capture code that waits for an edge that never arrives. Examples are a falling edge under the rising-edge code, or any pin movement under a neighbour-source code. A missing capture only shows up as a register that did not change. So the bench first loads the counter input with a fresh value, then moves the pin, then waits longer than the synchroniser latency before it checks that the register still holds its old value. The same approach covers captures that the fast-clock flag suppresses. For compare runs, the counter input is held equal to the register for several cycles. This shows that a toggle happens only once per run of equal cycles.

// File: rtl/tmr_cc_pkg.sv
package tmr_cc_pkg;

    localparam int unsigned CTL_W = 4;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'b00,
        ACT_LOW    = 2'b01,
        ACT_HIGH   = 2'b10,
        ACT_TOGGLE = 2'b11
    } cmp_act_e;

    typedef enum logic [1:0] {
        SRC_RISE  = 2'b00,
        SRC_FALL  = 2'b01,
        SRC_BOTH  = 2'b10,
        SRC_NEIGH = 2'b11
    } cap_src_e;

    typedef struct packed {
        logic     capture;
        logic     out_en;
        logic     init_lvl;
        cmp_act_e act;
        cap_src_e src;
    } ctl_dec_t;

endpackage

// File: rtl/tmr_cc_decode.sv
module tmr_cc_decode
    import tmr_cc_pkg::*;
#(
    parameter bit HAS_XSRC = 1'b1
) (
    input  logic [CTL_W-1:0] ctl_i,
    output ctl_dec_t         dec_o
);

    cap_src_e pin_src;
    cap_src_e src_sel;

    always_comb begin
        if (ctl_i[1])      pin_src = SRC_BOTH;
        else if (ctl_i[0]) pin_src = SRC_FALL;
        else               pin_src = SRC_RISE;
    end

    generate
        if (HAS_XSRC) begin : g_xsrc
            always_comb begin
                src_sel = (ctl_i[3:2] == 2'b11) ? SRC_NEIGH : pin_src;
            end
        end else begin : g_pin_only
            always_comb begin
                src_sel = pin_src;
            end
        end
    endgenerate

    always_comb begin
        dec_o          = '0;
        dec_o.capture  = ctl_i[3];
        dec_o.out_en   = !ctl_i[3] && (ctl_i[1:0] != 2'b00);
        dec_o.init_lvl = ctl_i[2];
        dec_o.act      = cmp_act_e'(ctl_i[1:0]);
        dec_o.src      = src_sel;
    end

endmodule

// File: rtl/tmr_cc_edge.sv
module tmr_cc_edge #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pin_i,
    output logic rise_o,
    output logic fall_o
);

    localparam int unsigned CHAIN_W = STAGES + 1;

    logic [CHAIN_W-1:0] chain_d;
    logic [CHAIN_W-1:0] chain_q;

    always_comb begin
        chain_d = {chain_q[CHAIN_W-2:0], pin_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= chain_d;
    end

    assign rise_o =  chain_q[STAGES-1] && !chain_q[STAGES];
    assign fall_o = !chain_q[STAGES-1] &&  chain_q[STAGES];

endmodule

// File: rtl/tmr_cc_match.sv
module tmr_cc_match #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] gr_i,
    output logic             hit_o
);

    logic eq;
    logic eq_prev_d;
    logic eq_prev_q;

    always_comb begin
        eq        = (cnt_i == gr_i);
        eq_prev_d = eq;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) eq_prev_q <= 1'b0;
        else         eq_prev_q <= eq_prev_d;
    end

    assign hit_o = eq && !eq_prev_q;

endmodule

// File: rtl/tmr_cc_chan.sv
module tmr_cc_chan
    import tmr_cc_pkg::*;
#(
    parameter int unsigned CNT_W       = 16,
    parameter int unsigned SYNC_STAGES = 2,
    parameter bit          HAS_XSRC    = 1'b1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_ctl_i,
    input  logic             wr_reg_i,
    input  logic [CNT_W-1:0] wdata_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             pin_i,
    input  logic             nb_cnt_evt_i,
    input  logic             nb_fast_clk_i,
    output logic             pin_o,
    output logic             pin_oe_o,
    output logic             flag_o,
    output logic [CNT_W-1:0] gr_o
);

    typedef struct packed {
        logic [CTL_W-1:0] ctl;
        logic [CNT_W-1:0] gr;
        logic             pin;
        logic             flag;
    } chan_st_t;

    chan_st_t st_d;
    chan_st_t st_q;

    logic [CTL_W-1:0] ctl_cur;
    ctl_dec_t         dec;
    logic             hit;
    logic             rise;
    logic             fall;
    logic             trig;

    assign ctl_cur = st_q.ctl;

    tmr_cc_decode #(.HAS_XSRC(HAS_XSRC)) i_decode (
        .ctl_i (ctl_cur),
        .dec_o (dec)
    );

    tmr_cc_edge #(.STAGES(SYNC_STAGES)) i_edge (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .pin_i  (pin_i),
        .rise_o (rise),
        .fall_o (fall)
    );

    tmr_cc_match #(.CNT_W(CNT_W)) i_match (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .cnt_i  (cnt_i),
        .gr_i   (st_q.gr),
        .hit_o  (hit)
    );

    always_comb begin
        unique case (dec.src)
            SRC_RISE:  trig = rise;
            SRC_FALL:  trig = fall;
            SRC_BOTH:  trig = rise || fall;
            SRC_NEIGH: trig = nb_cnt_evt_i && !nb_fast_clk_i;
            default:   trig = 1'b0;
        endcase
    end

    always_comb begin
        st_d      = st_q;
        st_d.flag = 1'b0;

        if (!dec.capture) begin
            if (hit) begin
                st_d.flag = 1'b1;
                unique case (dec.act)
                    ACT_LOW:    st_d.pin = 1'b0;
                    ACT_HIGH:   st_d.pin = 1'b1;
                    ACT_TOGGLE: st_d.pin = !st_q.pin;
                    default:    st_d.pin = st_q.pin;
                endcase
            end
        end else if (trig) begin
            st_d.flag = 1'b1;
            st_d.gr   = cnt_i;
        end

        if (wr_reg_i) begin
            st_d.gr = wdata_i;
        end

        if (wr_ctl_i) begin
            st_d.ctl = wdata_i[CTL_W-1:0];
            if (!wdata_i[3] && (wdata_i[1:0] != 2'b00)) begin
                st_d.pin = wdata_i[2];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.ctl  <= '0;
            st_q.gr   <= '1;
            st_q.pin  <= 1'b0;
            st_q.flag <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pin_o    = st_q.pin;
    assign pin_oe_o = dec.out_en;
    assign flag_o   = st_q.flag;
    assign gr_o     = st_q.gr;

endmodule

// File: rtl/tmr_cc_chk.sv
module tmr_cc_chk #(
    parameter int unsigned CNT_W    = 16,
    parameter bit          HAS_XSRC = 1'b1
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             wr_ctl_i,
    input logic             wr_reg_i,
    input logic [CNT_W-1:0] wdata_i,
    input logic [CNT_W-1:0] cnt_i,
    input logic             nb_cnt_evt_i,
    input logic             nb_fast_clk_i,
    input logic             pin_o,
    input logic             pin_oe_o,
    input logic             flag_o,
    input logic [CNT_W-1:0] gr_o,
    input logic [3:0]       ctl_i
);

    // R2: disabled compare codes never enable the pin
    p_dis_oe_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!ctl_i[3] && ctl_i[1:0] == 2'b00) |-> !pin_oe_o);

    // R3: the initial level lands with the field write
    p_init_lvl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_ctl_i && !wdata_i[3] && wdata_i[1:0] != 2'b00)
        |=> (pin_o == $past(wdata_i[2])) && pin_oe_o);

    // R5: a compare flag lasts one cycle
    p_flag_one_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag_o && !ctl_i[3] && $stable(ctl_i) && !wr_ctl_i) |=> !flag_o);

    // R6: capture mode never drives the pin
    p_cap_oe_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ctl_i[3] |-> !pin_oe_o);

    // R10: a bus write to the register wins
    p_wr_prio_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_reg_i |=> gr_o == $past(wdata_i));

    generate
        if (HAS_XSRC) begin : g_xsrc_chk
            // R8: neighbour event captures the counter
            p_xcap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (ctl_i[3:2] == 2'b11 && nb_cnt_evt_i && !nb_fast_clk_i
                 && !wr_reg_i && !wr_ctl_i)
                |=> (gr_o == $past(cnt_i)) && flag_o);

            // R9: undivided neighbour clock blocks capture
            p_xfast_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (ctl_i[3:2] == 2'b11 && nb_fast_clk_i && !wr_reg_i && !wr_ctl_i)
                |=> $stable(gr_o) && !flag_o);
        end
    endgenerate

endmodule

bind tmr_cc_chan tmr_cc_chk #(.CNT_W(CNT_W), .HAS_XSRC(HAS_XSRC)) i_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_ctl_i      (wr_ctl_i),
    .wr_reg_i      (wr_reg_i),
    .wdata_i       (wdata_i),
    .cnt_i         (cnt_i),
    .nb_cnt_evt_i  (nb_cnt_evt_i),
    .nb_fast_clk_i (nb_fast_clk_i),
    .pin_o         (pin_o),
    .pin_oe_o      (pin_oe_o),
    .flag_o        (flag_o),
    .gr_o          (gr_o),
    .ctl_i         (ctl_cur)
);

// File: tb/test_tmr_cc_chan.sv
module test_tmr_cc_chan;

    localparam int unsigned CNT_W      = 16;
    localparam time         CLK_PERIOD = 10ns;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             wr_ctl, wr_reg;
    logic [CNT_W-1:0] wdata, cnt;
    logic             pin_in, nb_evt, nb_fast;
    logic             pin_out, pin_oe, flag;
    logic [CNT_W-1:0] gr;

    int n_total = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_cc_chan #(.CNT_W(CNT_W)) i_tmr_cc_chan (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .wr_ctl_i      (wr_ctl),
        .wr_reg_i      (wr_reg),
        .wdata_i       (wdata),
        .cnt_i         (cnt),
        .pin_i         (pin_in),
        .nb_cnt_evt_i  (nb_evt),
        .nb_fast_clk_i (nb_fast),
        .pin_o         (pin_out),
        .pin_oe_o      (pin_oe),
        .flag_o        (flag),
        .gr_o          (gr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic write_ctl(input logic [3:0] code);
        wr_ctl = 1'b1; wdata = {{(CNT_W-4){1'b0}}, code};
        tick(1);
        wr_ctl = 1'b0;
    endtask

    task automatic write_reg(input logic [CNT_W-1:0] v);
        wr_reg = 1'b1; wdata = v;
        tick(1);
        wr_reg = 1'b0;
    endtask

    // counter goes away and comes back to the register value
    task automatic hit_once(input logic [CNT_W-1:0] v);
        cnt = v + 1'b1; tick(1);
        cnt = v; tick(1);
    endtask

    task automatic t_reset();
        chk("R1 gr", gr, 32'hFFFF);
        chk("R1 pin", pin_out, 0);
        chk("R1 oe", pin_oe, 0);
        chk("R1 flag", flag, 0);
    endtask

    task automatic t_compare_init();
        write_ctl(4'b0001);
        chk("R3 init0 pin", pin_out, 0);
        chk("R2 oe on", pin_oe, 1);
        write_ctl(4'b0111);
        chk("R3 init1 pin", pin_out, 1);
        write_ctl(4'b0011);
        chk("R3 init0 after 1", pin_out, 0);
    endtask

    task automatic t_compare_actions();
        write_reg(16'd5);
        cnt = 16'd0;
        write_ctl(4'b0011);
        cnt = 16'd5; tick(1);
        chk("R4 toggle 1", pin_out, 1);
        chk("R5 flag on", flag, 1);
        tick(1);
        chk("R4 hold run", pin_out, 1);
        chk("R5 flag one cycle", flag, 0);
        tick(2);
        chk("R4 no retoggle", pin_out, 1);
        hit_once(16'd5);
        chk("R4 toggle 2", pin_out, 0);
        cnt = 16'd0;
        write_ctl(4'b0101);
        chk("R3 0101 init", pin_out, 1);
        hit_once(16'd5);
        chk("R4 drive low", pin_out, 0);
        write_ctl(4'b0010);
        chk("R3 0010 init", pin_out, 0);
        hit_once(16'd5);
        chk("R4 drive high", pin_out, 1);
    endtask

    task automatic t_disabled();
        write_ctl(4'b0100);
        chk("R2 0100 oe off", pin_oe, 0);
        hit_once(16'd5);
        chk("R11 flag", flag, 1);
        chk("R11 pin kept", pin_out, 1);
        write_ctl(4'b0000);
        chk("R2 0000 oe off", pin_oe, 0);
        hit_once(16'd5);
        chk("R11 pin kept 0000", pin_out, 1);
    endtask

    // pin changes before edge k; expect capture visible after edge k+2
    task automatic pin_move(input logic lvl, input logic [CNT_W-1:0] c);
        cnt = c; pin_in = lvl;
        tick(3);
    endtask

    task automatic t_capture();
        pin_in = 1'b0; cnt = 16'd0;
        write_ctl(4'b1000);
        tick(3);
        chk("R6 oe off", pin_oe, 0);
        cnt = 16'h1234; pin_in = 1'b1;
        tick(2);
        chk("R7 not yet", gr, 32'h0005);
        tick(1);
        chk("R7 rise gr", gr, 32'h1234);
        chk("R7 rise flag", flag, 1);
        tick(1);
        chk("R7 flag one cycle", flag, 0);
        pin_move(1'b0, 16'h2222); tick(3);
        chk("R7 fall ignored", gr, 32'h1234);
        write_ctl(4'b1001);
        pin_move(1'b1, 16'h3333); tick(3);
        chk("R7 rise ignored", gr, 32'h1234);
        pin_move(1'b0, 16'h4444);
        chk("R7 fall gr", gr, 32'h4444);
        tick(1);
        write_ctl(4'b1010);
        pin_move(1'b1, 16'h5555);
        chk("R7 both rise", gr, 32'h5555);
        tick(1);
        pin_move(1'b0, 16'h6666);
        chk("R7 both fall", gr, 32'h6666);
        tick(2);
    endtask

    task automatic t_neighbour();
        write_ctl(4'b1100);
        pin_move(1'b1, 16'h7070); tick(3);
        chk("R8 pin ignored", gr, 32'h6666);
        cnt = 16'h0077; nb_evt = 1'b1; tick(1);
        nb_evt = 1'b0;
        chk("R8 gr", gr, 32'h0077);
        chk("R8 flag", flag, 1);
        cnt = 16'h0099; nb_evt = 1'b1; nb_fast = 1'b1; tick(1);
        nb_evt = 1'b0;
        chk("R9 gr kept", gr, 32'h0077);
        chk("R9 no flag", flag, 0);
        nb_fast = 1'b0;
        cnt = 16'h1111; nb_evt = 1'b1; wr_reg = 1'b1; wdata = 16'hABCD; tick(1);
        nb_evt = 1'b0; wr_reg = 1'b0;
        chk("R10 write wins", gr, 32'hABCD);
    endtask

    initial begin
        rst_n = 1'b0; wr_ctl = 1'b0; wr_reg = 1'b0; wdata = '0; cnt = '0;
        pin_in = 1'b0; nb_evt = 1'b0; nb_fast = 1'b0;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_compare_init();
        t_compare_actions();
        t_disabled();
        t_capture();
        t_neighbour();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_total++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

endmodule